// File: doc/BRIEF.md
# Serial-to-Parallel Output Expander with Strobed Latch

This block turns a slow four-wire serial stream from a microcontroller into a 20-bit parallel output word. The four wires are serial data, a shift clock, an active-low strobe and an active-low clear. Each rising edge of the shift clock pushes one data bit into a shift register. A separate output latch drives the parallel pins. While the strobe is high, that latch keeps the word it already holds. While the strobe is low, the latch copies the shift register and keeps following it. Clear empties only the latch. The last shift stage is brought out as a serial output, so that devices can be chained into longer words.

The block runs on a fast system clock. All four serial-side inputs pass through two-flop synchronizers. A shift is taken on the rising edge of the synchronized shift clock, so one shift-clock pulse gives exactly one shift however long it stays high. No handshake is needed: the serial wires are plain control pins driven by a slow master.

Top module: `sipo_expander`

## Requirements
- R1: On each rising edge of the shift clock, the register moves one place towards the last stage and takes the serial data bit into its first stage. Without a rising edge, the register keeps its contents.
- R2: After 20 shifts, the first bit shifted in appears on `par_q[19]` and the most recent bit appears on `par_q[0]`.
- R3: While the strobe is high and clear is high, the parallel outputs keep their value while shifting goes on.
- R4: While the strobe is low and clear is high, the parallel outputs equal the shift register and follow every further shift.
- R5: While clear is low, the parallel outputs are all zero, whatever the strobe and shift clock do.
- R6: Clear does not alter the shift register. When clear is released with the strobe low, the outputs show the bits shifted in before and during the clear.
- R7: `ser_dout` equals the last shift stage and ignores clear and strobe. Two chained devices shifted 40 times hold the first 20 bits in the downstream device, with its `par_q[19]` holding bit 0.
- R8: An active-low asynchronous `rst_n` sets the shift register and the latch to zero, so `par_q` and `ser_dout` read zero after reset.
- R9: A shift clock held high for many system clocks causes exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_din | input | 1 | Serial data bit |
| shift_clk | input | 1 | Shift clock; a shift happens on its rising edge |
| strobe_n | input | 1 | Active-low strobe; when low, the latch is transparent |
| clear_n | input | 1 | Active-low clear of the output latch |
| par_q | output | 20 | Parallel latch outputs, from P1 on bit 0 to P20 on bit 19 |
| ser_dout | output | 1 | Cascade output from the last shift stage |

## Verification
The assertions assume that the serial-side inputs change slowly compared with the system clock. They also assume that serial data is stable for several system clocks on either side of each shift-clock rise, so that the synchronized data and the detected edge belong to the same bit. The stimulus keeps every serial-side level for eight system clocks before the next change, and it samples only after that settling window. In the two-device chain, the downstream device samples the upstream serial output before the upstream shift lands, because the two see the shift edge in the same cycle.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  typedef struct packed {
    logic data;
    logic sclk;
    logic strobe_n;
    logic clear_n;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam ctl_t CTL_IDLE = '{data: 1'b0, sclk: 1'b0, strobe_n: 1'b1, clear_n: 1'b1};
endpackage

// File: rtl/sipo_sync.sv
module sipo_sync #(
  parameter int STAGES = 2,
  parameter int W = 4,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= INIT;
          else        stage_q[s] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= INIT;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/sipo_shifter.sv
module sipo_shifter #(
  parameter int DEPTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             data_s,
  output logic [DEPTH-1:0] sr_q,
  output logic             shift_pulse
);
  logic sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_s;

  assign shift_pulse = sclk_s & ~sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           sr_q <= '0;
    else if (shift_pulse) sr_q <= {sr_q[DEPTH-2:0], data_s};
endmodule

// File: rtl/sipo_latch.sv
module sipo_latch #(
  parameter int DEPTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_n_s,
  input  logic             strobe_n_s,
  input  logic [DEPTH-1:0] sr_in,
  output logic [DEPTH-1:0] lat_q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          lat_q <= '0;
    else if (!clear_n_s) lat_q <= '0;
    else if (!strobe_n_s) lat_q <= sr_in;
endmodule

// File: rtl/sipo_expander.sv
module sipo_expander
  import sipo_pkg::*;
#(
  parameter int DEPTH = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_din,
  input  logic             shift_clk,
  input  logic             strobe_n,
  input  logic             clear_n,
  output logic [DEPTH-1:0] par_q,
  output logic             ser_dout
);
  ctl_t ctl_raw, ctl_s;
  logic [DEPTH-1:0] sr_q;
  logic shift_pulse;
  logic data_s, sclk_s, stb_s, clr_s;

  assign ctl_raw = '{data: ser_din, sclk: shift_clk, strobe_n: strobe_n, clear_n: clear_n};

  sipo_sync #(.STAGES(SYNC_STAGES), .W(CTL_W), .INIT(CTL_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ctl_raw), .sync_out(ctl_s)
  );

  assign data_s = ctl_s.data;
  assign sclk_s = ctl_s.sclk;
  assign stb_s  = ctl_s.strobe_n;
  assign clr_s  = ctl_s.clear_n;

  sipo_shifter #(.DEPTH(DEPTH)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .data_s(data_s),
    .sr_q(sr_q), .shift_pulse(shift_pulse)
  );

  sipo_latch #(.DEPTH(DEPTH)) u_latch (
    .clk(clk), .rst_n(rst_n), .clear_n_s(clr_s), .strobe_n_s(stb_s),
    .sr_in(sr_q), .lat_q(par_q)
  );

  assign ser_dout = sr_q[DEPTH-1];
endmodule

// File: rtl/sipo_expander_checker.sv
module sipo_expander_checker #(
  parameter int DEPTH = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_pulse,
  input logic             data_s,
  input logic             stb_s,
  input logic             clr_s,
  input logic [DEPTH-1:0] sr,
  input logic [DEPTH-1:0] par_q,
  input logic             ser_dout
);
  assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> sr[0] == $past(data_s));
  assert_no_edge_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_pulse |=> $stable(sr));
  assert_shift_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> sr[DEPTH-1:1] == $past(sr[DEPTH-2:0]));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s && stb_s) |=> $stable(par_q));
  assert_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s && !stb_s) |=> par_q == $past(sr));
  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> par_q == '0);
  assert_clear_keeps_sr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && !shift_pulse) |=> $stable(sr));
  assert_cascade_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_pulse |=> $stable(ser_dout));
  assert_single_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> !shift_pulse);
endmodule

bind sipo_expander sipo_expander_checker #(.DEPTH(DEPTH)) u_checker (
  .clk(clk), .rst_n(rst_n), .shift_pulse(shift_pulse), .data_s(data_s),
  .stb_s(stb_s), .clr_s(clr_s), .sr(sr_q), .par_q(par_q), .ser_dout(ser_dout)
);

// File: tb/sipo_expander_bench.sv
module sipo_expander_bench;
  localparam int W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_i = 1'b0, sclk_i = 1'b0, stb_n_i = 1'b1, clr_n_i = 1'b1;
  logic [W-1:0] pa, pb;
  logic soa, sob;

  logic [W-1:0] ref_a = '0, ref_b = '0, lat_a = '0, lat_b = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sipo_expander u_sipo_expander (
    .clk(clk), .rst_n(rst_n), .ser_din(data_i), .shift_clk(sclk_i),
    .strobe_n(stb_n_i), .clear_n(clr_n_i), .par_q(pa), .ser_dout(soa)
  );

  sipo_expander u_sipo_expander_b (
    .clk(clk), .rst_n(rst_n), .ser_din(soa), .shift_clk(sclk_i),
    .strobe_n(stb_n_i), .clear_n(clr_n_i), .par_q(pb), .ser_dout(sob)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic track();
    if (!clr_n_i) begin lat_a = '0; lat_b = '0; end
    else if (!stb_n_i) begin lat_a = ref_a; lat_b = ref_b; end
  endtask

  task automatic shift_bit(input logic b, input int high_cycles = 8);
    data_i = b; settle();
    sclk_i = 1'b1; repeat (high_cycles) @(negedge clk);
    sclk_i = 1'b0; settle();
    ref_b = {ref_b[W-2:0], ref_a[W-1]};
    ref_a = {ref_a[W-2:0], b};
    track();
  endtask

  task automatic set_ctl(input logic stb, input logic clr);
    stb_n_i = stb; clr_n_i = clr; settle(); track();
  endtask

  task automatic t_reset();
    chk("R8 par_q after reset", pa, '0);
    chk("R8 ser_dout after reset", {{(W-1){1'b0}}, soa}, '0);
  endtask

  task automatic t_hold();
    logic [W-1:0] pat = 20'hA5C3E;
    set_ctl(1'b1, 1'b1);
    for (int i = W-1; i >= 0; i--) begin
      shift_bit(pat[i]);
      if (i % 5 == 0) chk("R3 hold while shifting", pa, lat_a);
    end
    chk("R7 ser_dout is last stage", {{(W-1){1'b0}}, soa}, {{(W-1){1'b0}}, ref_a[W-1]});
  endtask

  task automatic t_transfer();
    logic [W-1:0] pat = 20'h80001;
    for (int i = W-1; i >= 0; i--) shift_bit(pat[i]);
    chk("R3 hold before strobe", pa, lat_a);
    set_ctl(1'b0, 1'b1);
    chk("R4 transfer on strobe", pa, ref_a);
    chk("R2 first bit on par_q[19], last on par_q[0]", {18'b0, pa[W-1], pa[0]}, {18'b0, 1'b1, 1'b1});
    chk("R2 middle bits zero", {1'b0, pa[W-2:1], 1'b0}, '0);
    set_ctl(1'b1, 1'b1);
  endtask

  task automatic t_follow();
    set_ctl(1'b0, 1'b1);
    for (int i = 0; i < 6; i++) begin
      shift_bit(i[0] ^ i[1]);
      chk("R4 latch follows each shift", pa, ref_a);
    end
    set_ctl(1'b1, 1'b1);
    shift_bit(1'b1);
    chk("R3 latch frozen after strobe high", pa, lat_a);
  endtask

  task automatic t_clear();
    set_ctl(1'b1, 1'b0);
    chk("R5 clear zeroes outputs with strobe high", pa, '0);
    set_ctl(1'b0, 1'b0);
    shift_bit(1'b1);
    shift_bit(1'b0);
    chk("R5 clear beats strobe and shift", pa, '0);
    chk("R7 ser_dout ignores clear", {{(W-1){1'b0}}, soa}, {{(W-1){1'b0}}, ref_a[W-1]});
    set_ctl(1'b0, 1'b1);
    chk("R6 shift register kept through clear", pa, ref_a);
    set_ctl(1'b1, 1'b1);
  endtask

  task automatic t_long_clk();
    set_ctl(1'b0, 1'b1);
    shift_bit(1'b1, 40);
    chk("R9 long shift clock gives one shift", pa, ref_a);
    shift_bit(1'b0, 3);
    chk("R1 short shift clock still shifts", pa, ref_a);
    set_ctl(1'b1, 1'b1);
  endtask

  task automatic t_cascade();
    logic [2*W-1:0] pat = 40'hC3_5A96_0F1E;
    set_ctl(1'b1, 1'b1);
    for (int i = 0; i < 2*W; i++) shift_bit(pat[i]);
    set_ctl(1'b0, 1'b1);
    chk("R7 upstream word", pa, ref_a);
    chk("R7 downstream word", pb, ref_b);
    chk("R7 downstream P20 holds bit 0", {{(W-1){1'b0}}, pb[W-1]}, {{(W-1){1'b0}}, pat[0]});
    chk("R2 upstream P1 holds last bit", {{(W-1){1'b0}}, pa[0]}, {{(W-1){1'b0}}, pat[2*W-1]});
    set_ctl(1'b1, 1'b1);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_hold();
    t_transfer();
    t_follow();
    t_clear();
    t_long_clk();
    t_cascade();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule